// File: doc/BRIEF.md
# Multiplexed-Bus Burst Slave Bridge

This block connects an external processor to one port of an on-chip dual-port memory through a multiplexed bus. The bus has an address-latch strobe (active high), a read strobe and a write strobe (both active low), and one shared address/data path. A transfer starts with an address phase. While the latch strobe is high, the bus carries the start address, and the block takes that address when the strobe falls. Each read or write strobe after that moves one data word, and the internal address steps by one when each strobe ends. Bursts of any length therefore reach consecutive locations. The other memory port belongs to a second processor, so the memory works as a mailbox between the two.

The block has a single free-running system clock, several times faster than the bus transfer rate. The strobes are never used as clocks. Each strobe passes through a synchronizer, and a detector turns its edges into one-cycle pulses. The bus value is registered on every cycle in which the address or write phase is active, and the value held just before the release edge is the one used. All memory-port outputs and the bus output-enable come straight from flops.

The pad logic outside the block joins `bus_in`, `bus_out` and `bus_oe` into the bidirectional bus. The host must keep the bus stable for at least two clock cycles after an address or write strobe is released. It must leave at least three idle clock cycles between strobes and hold each read strobe low for at least six clock cycles.

Top module: `mxb_burst_bridge`

## Requirements
- R1: After reset, `mem_we`, `mem_re` and `bus_oe` are 0 and `bus_out` is all zeros.
- R2: When the address-latch strobe goes from high to low, the low ADDR_W bits of the bus value present while it was high become the address of the next memory access.
- R3: Each low-to-high transition of the write strobe produces exactly one `mem_we` pulse, one clock wide. The pulse carries `mem_addr` equal to the current address and `mem_wdata` equal to the bus value held during that strobe.
- R4: The address increases by one at the end of every read or write strobe, so successive strobes in a burst reach consecutive locations.
- R5: The address counts modulo 2^ADDR_W, so a burst that passes the highest location continues at address 0.
- R6: Each high-to-low transition of the read strobe produces exactly one `mem_re` pulse with the current address. The word the memory returns MEM_RD_LAT cycles later is placed on `bus_out`, and it is there no later than six clock cycles after the strobe fell.
- R7: `bus_oe` is 1 only while the synchronized read strobe is low. It is 0 during write and address phases and returns to 0 within four clock cycles after the read strobe rises.
- R8: A new address phase in the middle of a burst replaces the running address, and the next access uses the newly latched address.
- R9: An address phase alone causes no memory access, and `mem_we` and `mem_re` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, free running |
| rst | input | 1 | Synchronous reset, active high |
| ale | input | 1 | Address-latch strobe from the bus, active high, asynchronous |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| bus_in | input | DATA_W | Value received from the shared address/data bus |
| bus_out | output | DATA_W | Read data to drive onto the bus |
| bus_oe | output | 1 | Bus output-enable, 1 while read data is driven |
| mem_addr | output | ADDR_W | Memory port address |
| mem_wdata | output | DATA_W | Memory port write data |
| mem_we | output | 1 | Memory port write enable, one-cycle pulse |
| mem_re | output | 1 | Memory port read request, one-cycle pulse |
| mem_rdata | input | DATA_W | Memory port read data, valid MEM_RD_LAT cycles after `mem_re` |

## Verification
A corrupted address counter first shows up as a `mem_we` or `mem_re` pulse with the wrong `mem_addr`. That happens on the very next strobe, about three cycles after its edge. It then appears as wrong data when the burst is read back. A broken synchronizer or edge detector shows up as missing or doubled memory pulses, or as an output-enable that is asserted outside the read strobe or stays on after it. Each of these can be seen within a few cycles of the offending strobe. A stale capture register appears as the wrong `mem_wdata` on that same write pulse.

// File: rtl/mxb_pkg.sv
package mxb_pkg;

    // index of each bus strobe in the synchronizer bank
    localparam int STB_ALE = 0;
    localparam int STB_RD  = 1;
    localparam int STB_WR  = 2;
    localparam int NUM_STB = 3;

    // idle (deasserted) level of each strobe, indexed as above
    localparam logic [NUM_STB-1:0] STB_IDLE = 3'b110;

    // synchronized view of one strobe
    typedef struct packed {
        logic lvl;   // synchronized level
        logic rise;  // one-cycle pulse on low-to-high
        logic fall;  // one-cycle pulse on high-to-low
    } strobe_t;

    // kind of access the bridge issues on its memory port
    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_READ  = 2'd2
    } access_e;

endpackage

// File: rtl/mxb_strobe_sync.sv
module mxb_strobe_sync
    import mxb_pkg::*;
#(
    parameter int   STAGES = 2,
    parameter logic IDLE   = 1'b0
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    raw,
    output strobe_t stb
);

    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] shreg;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= {STAGES{IDLE}};
            prev  <= IDLE;
        end else begin
            shreg <= {shreg[STAGES-2:0], raw};
            prev  <= shreg[LAST];
        end
    end

    // both operands are flops, so the pulses cannot glitch
    always_comb begin
        stb.lvl  = shreg[LAST];
        stb.rise = shreg[LAST] & ~prev;
        stb.fall = ~shreg[LAST] & prev;
    end

endmodule

// File: rtl/mxb_bus_capture.sv
module mxb_bus_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);

    // follows the bus while a phase is active; holds after release
    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (en) q <= d;
    end

endmodule

// File: rtl/mxb_addr_ctr.sv
module mxb_addr_ctr #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step,
    output logic [ADDR_W-1:0] cnt
);

    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    // load has priority; step wraps naturally at 2^ADDR_W
    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (load) cnt <= load_val;
        else if (step) cnt <= cnt + ONE;
    end

endmodule

// File: rtl/mxb_read_path.sv
module mxb_read_path #(
    parameter int DATA_W     = 16,
    parameter int MEM_RD_LAT = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch,
    input  logic              rd_active,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe
);

    logic [MEM_RD_LAT-1:0] pend;

    generate
        if (MEM_RD_LAT == 1) begin : g_lat1
            always_ff @(posedge clk) begin
                if (rst) pend <= '0;
                else     pend <= fetch;
            end
        end else begin : g_latn
            always_ff @(posedge clk) begin
                if (rst) pend <= '0;
                else     pend <= {pend[MEM_RD_LAT-2:0], fetch};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_out <= '0;
            bus_oe  <= 1'b0;
        end else begin
            if (pend[MEM_RD_LAT-1]) bus_out <= mem_rdata;
            bus_oe <= rd_active;
        end
    end

endmodule

// File: rtl/mxb_burst_bridge.sv
module mxb_burst_bridge
    import mxb_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2,
    parameter int MEM_RD_LAT  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ale,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

    // ---------------- strobe synchronizers ----------------
    logic    [NUM_STB-1:0] raw_stb;
    strobe_t               stb [NUM_STB];

    assign raw_stb[STB_ALE] = ale;
    assign raw_stb[STB_RD]  = rd_n;
    assign raw_stb[STB_WR]  = wr_n;

    generate
        for (genvar i = 0; i < NUM_STB; i++) begin : g_sync
            mxb_strobe_sync #(
                .STAGES (SYNC_STAGES),
                .IDLE   (STB_IDLE[i])
            ) u_sync (
                .clk (clk),
                .rst (rst),
                .raw (raw_stb[i]),
                .stb (stb[i])
            );
        end
    endgenerate

    logic ale_done, wr_done, rd_start, rd_done, rd_low;
    assign ale_done = stb[STB_ALE].fall;
    assign wr_done  = stb[STB_WR].rise;
    assign rd_start = stb[STB_RD].fall;
    assign rd_done  = stb[STB_RD].rise;
    assign rd_low   = ~stb[STB_RD].lvl;

    // ---------------- bus capture ----------------
    logic              cap_en;
    logic [DATA_W-1:0] bus_q;

    assign cap_en = stb[STB_ALE].lvl | ~stb[STB_WR].lvl;

    mxb_bus_capture #(.DATA_W(DATA_W)) u_cap (
        .clk (clk),
        .rst (rst),
        .en  (cap_en),
        .d   (bus_in),
        .q   (bus_q)
    );

    // ---------------- address counter ----------------
    logic [ADDR_W-1:0] cur_addr;

    mxb_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .load     (ale_done),
        .load_val (bus_q[ADDR_W-1:0]),
        .step     (wr_done | rd_done),
        .cnt      (cur_addr)
    );

    // ---------------- memory port ----------------
    access_e acc;

    always_comb begin
        if (wr_done)       acc = ACC_WRITE;
        else if (rd_start) acc = ACC_READ;
        else               acc = ACC_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_addr  <= '0;
            mem_wdata <= '0;
            mem_we    <= 1'b0;
            mem_re    <= 1'b0;
        end else begin
            mem_we <= (acc == ACC_WRITE);
            mem_re <= (acc == ACC_READ);
            if (acc != ACC_NONE) mem_addr <= cur_addr;
            if (acc == ACC_WRITE) mem_wdata <= bus_q;
        end
    end

    // ---------------- read return path ----------------
    mxb_read_path #(
        .DATA_W     (DATA_W),
        .MEM_RD_LAT (MEM_RD_LAT)
    ) u_rd (
        .clk       (clk),
        .rst       (rst),
        .fetch     (mem_re),
        .rd_active (rd_low),
        .mem_rdata (mem_rdata),
        .bus_out   (bus_out),
        .bus_oe    (bus_oe)
    );

    // ---------------- assertions ----------------
    logic              trk_valid;
    logic              trk_reload;
    logic [ADDR_W-1:0] trk_last;
    logic [ADDR_W-1:0] trk_start;

    always_ff @(posedge clk) begin
        if (rst) begin
            trk_valid  <= 1'b0;
            trk_reload <= 1'b0;
            trk_last   <= '0;
            trk_start  <= '0;
        end else if (mem_we | mem_re) begin
            trk_valid  <= 1'b1;
            trk_reload <= 1'b0;
            trk_last   <= mem_addr;
        end else if (ale_done) begin
            trk_reload <= 1'b1;
            trk_start  <= bus_q[ADDR_W-1:0];
        end
    end

    a_r2_start_addr: assert property (@(posedge clk) disable iff (rst)
        ((mem_we || mem_re) && trk_reload) |-> (mem_addr == trk_start));

    a_r4_addr_step: assert property (@(posedge clk) disable iff (rst)
        ((mem_we || mem_re) && trk_valid && !trk_reload)
            |-> (mem_addr == trk_last + ADDR_ONE));

    a_r3_we_single: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

    a_r6_re_single: assert property (@(posedge clk) disable iff (rst)
        mem_re |=> !mem_re);

    a_r9_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re));

    a_r9_ale_no_access: assert property (@(posedge clk) disable iff (rst)
        stb[STB_ALE].rise |-> !(mem_we || mem_re));

    a_r7_oe_not_on_write: assert property (@(posedge clk) disable iff (rst)
        (mem_we || stb[STB_WR].fall) |-> !bus_oe);

endmodule

// File: tb/mxb_burst_bridge_test.sv
`timescale 1ns/1ps
module mxb_burst_bridge_test;

    localparam int AW = 10;
    localparam int DW = 16;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ale = 1'b0;
    logic          rd_n = 1'b1;
    logic          wr_n = 1'b1;
    logic [DW-1:0] bus_in = '0;
    logic [DW-1:0] bus_out;
    logic          bus_oe;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_we;
    logic          mem_re;
    logic [DW-1:0] mem_rdata = '0;

    always #2.5 clk = ~clk;

    mxb_burst_bridge #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst(rst), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
        .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_re(mem_re), .mem_rdata(mem_rdata)
    );

    // memory model (one-cycle read latency) and bench expectation
    logic [DW-1:0] model   [DEPTH];
    logic [DW-1:0] exp_mem [DEPTH];
    int            we_cnt = 0;
    int            re_cnt = 0;
    logic [AW-1:0] last_we_addr = '0;
    logic [DW-1:0] last_we_data = '0;
    logic [AW-1:0] last_re_addr = '0;

    always @(posedge clk) begin
        if (mem_we) begin
            model[mem_addr] <= mem_wdata;
            we_cnt       <= we_cnt + 1;
            last_we_addr <= mem_addr;
            last_we_data <= mem_wdata;
        end
        if (mem_re) begin
            mem_rdata    <= model[mem_addr];
            re_cnt       <= re_cnt + 1;
            last_re_addr <= mem_addr;
        end
    end

    int checks = 0;
    int failures = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // address phase; also checks that it issues no access (R9)
    task automatic bus_addr(input logic [AW-1:0] a);
        int w0 = we_cnt;
        int r0 = re_cnt;
        @(negedge clk);
        ale = 1'b1; bus_in = DW'(a);
        idle(3);
        ale = 1'b0;
        idle(3);
        bus_in = 16'hDEAD;
        idle(3);
        chk(we_cnt == w0 && re_cnt == r0, "R9", "access from address phase",
            32'(we_cnt - w0 + re_cnt - r0), 32'd0);
    endtask

    task automatic bus_write(input logic [DW-1:0] d, input logic [AW-1:0] ea,
                             input string req);
        int w0 = we_cnt;
        @(negedge clk);
        wr_n = 1'b0; bus_in = d;
        idle(4);
        chk(bus_oe == 1'b0, "R7", "oe during write", 32'(bus_oe), 32'd0);
        wr_n = 1'b1;
        idle(3);
        bus_in = 16'hBEEF;
        idle(3);
        chk(we_cnt == w0 + 1, "R3", "write pulse count", 32'(we_cnt - w0), 32'd1);
        chk(last_we_addr == ea, req, "write address", 32'(last_we_addr), 32'(ea));
        chk(last_we_data == d, "R3", "write data", 32'(last_we_data), 32'(d));
        exp_mem[ea] = d;
    endtask

    task automatic bus_read(input logic [AW-1:0] ea, input string req);
        int r0 = re_cnt;
        @(negedge clk);
        rd_n = 1'b0;
        idle(6);
        chk(re_cnt == r0 + 1, "R6", "read pulse count", 32'(re_cnt - r0), 32'd1);
        chk(last_re_addr == ea, req, "read address", 32'(last_re_addr), 32'(ea));
        chk(bus_oe == 1'b1, "R7", "oe during read", 32'(bus_oe), 32'd1);
        chk(bus_out == exp_mem[ea], "R6", "read data", 32'(bus_out), 32'(exp_mem[ea]));
        rd_n = 1'b1;
        idle(4);
        chk(bus_oe == 1'b0, "R7", "oe after read", 32'(bus_oe), 32'd0);
    endtask

    task automatic t_reset;
        chk(mem_we == 1'b0, "R1", "reset we", 32'(mem_we), 32'd0);
        chk(mem_re == 1'b0, "R1", "reset re", 32'(mem_re), 32'd0);
        chk(bus_oe == 1'b0, "R1", "reset oe", 32'(bus_oe), 32'd0);
        chk(bus_out == '0, "R1", "reset bus_out", 32'(bus_out), 32'd0);
    endtask

    task automatic t_write_burst;   // R2, R4
        bus_addr(10'h010);
        for (int i = 0; i < 4; i++)
            bus_write(16'h1100 + 16'(i * 7), 10'h010 + AW'(i), i == 0 ? "R2" : "R4");
    endtask

    task automatic t_read_burst;    // R4, R6
        bus_addr(10'h010);
        for (int i = 0; i < 4; i++)
            bus_read(10'h010 + AW'(i), i == 0 ? "R2" : "R4");
        bus_read(10'h014, "R4");    // untouched location, initial pattern
    endtask

    task automatic t_wrap;          // R5
        bus_addr(10'h3FE);
        bus_write(16'hA001, 10'h3FE, "R5");
        bus_write(16'hA002, 10'h3FF, "R5");
        bus_write(16'hA003, 10'h000, "R5");
        bus_addr(10'h3FF);
        bus_read(10'h3FF, "R5");
        bus_read(10'h000, "R5");
    endtask

    task automatic t_reload;        // R8
        bus_addr(10'h100);
        bus_write(16'h5151, 10'h100, "R8");
        bus_write(16'h5252, 10'h101, "R8");
        bus_addr(10'h200);
        bus_write(16'h6363, 10'h200, "R8");
        bus_read(10'h201, "R8");
        bus_addr(10'h101);
        bus_read(10'h101, "R8");
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            model[i]   = 16'h5A00 ^ DW'(i);
            exp_mem[i] = 16'h5A00 ^ DW'(i);
        end
        idle(4);
        t_reset();
        rst = 1'b0;
        idle(4);
        t_reset();
        t_write_burst();
        t_read_burst();
        t_wrap();
        t_reload();
        idle(5);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule